// File: doc/BRIEF.md
# Overcurrent Blanking Backoff Controller

This block sits beside the PWM generator of one switching converter and decides, one switching cycle at a time, whether the high-side switch may turn on. A strobe marks the boundary between switching cycles; at each strobe the block reads the overcurrent comparator and the output undervoltage comparator for the cycle that just ended. An overcurrent suppresses the high-side drive for a number of following switching cycles. That number doubles with each overcurrent that arrives in the first permitted cycle after a suppression, and it stops growing at a ceiling.

An undervoltage report starts a hiccup. The converter is held off for a fixed number of switching cycles. The block then issues a one-clock restart request and runs again with the backoff cleared. If the undervoltage is still present at the next strobe, the hiccup repeats.

The controller is a four-state machine. IDLE means disabled. RUN means the high side is permitted. BLANK means drive is suppressed after an overcurrent. HICCUP means the converter is shut off. Its transitions are:

- enable: IDLE to RUN.
- trip: RUN to BLANK.
- expire: BLANK to RUN.
- collapse: RUN or BLANK to HICCUP.
- retry: HICCUP to RUN.
- drop: any state to IDLE.

Top module: `ocb_ctrl`

## Requirements
- R1: After reset, and while `en` is low, `hs_permit`, `shut_off` and `restart_req` are all 0. One clock after `en` rises, `hs_permit` is 1.
- R2: A strobe in RUN with `oc_flag`=1 and `uv_flag`=0 drops `hs_permit` on the following clock. When no backoff has built up, exactly 1 switching cycle is blanked.
- R3: An overcurrent at the first strobe after a blank ends gives a blank twice as long as the previous one, so the lengths run 1, 2, 4, 8, 16.
- R4: The blank length never exceeds 2^MAX_SHIFT cycles, which is 16 by default. Further consecutive overcurrents keep it at 16.
- R5: A strobe in RUN with no overcurrent resets the next blank length to 1.
- R6: `oc_flag` at strobes during a blank is ignored. It neither lengthens the current blank nor grows the next one.
- R7: A strobe in RUN or BLANK with `uv_flag`=1 sets `shut_off`=1 and `hs_permit`=0 for exactly HICCUP_CYC switching cycles.
- R8: The strobe that ends the hiccup raises `restart_req` for exactly one clock, returns the block to RUN, and resets the blank length to 1.
- R9: When `uv_flag` and `oc_flag` are both 1 at the same strobe, the hiccup is entered, not a blank.
- R10: `en`=0 forces IDLE on the next clock from any state, with all outputs 0 and the backoff cleared. Strobes while disabled have no effect.
- R11: If `uv_flag` is present at the first strobe after a restart, the hiccup is entered again. This repeats for as long as the undervoltage persists.
- R12: While enabled and not in IDLE, outputs change only on a clock that samples `cyc_strobe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Converter enable |
| cyc_strobe | input | 1 | One-clock pulse at each switching-cycle boundary |
| oc_flag | input | 1 | Overcurrent comparator result for the ending cycle |
| uv_flag | input | 1 | Output undervoltage indication |
| hs_permit | output | 1 | High-side turn-on allowed in the current switching cycle |
| shut_off | output | 1 | Converter held off by a hiccup |
| restart_req | output | 1 | One-clock pulse requesting a restart after a hiccup |

## Verification
Overcurrent blanking and hiccup entry can both be triggered at one strobe. This happens when `oc_flag` and `uv_flag` are presented together, either in RUN or with an undervoltage arriving in the middle of a blank. The bench provokes both cases and expects `shut_off` to rise with no blank taken. A bound property independently requires the shutdown on the next clock after any such strobe. A second coincidence is the hiccup retry meeting a persistent undervoltage. That case is judged by counting exactly two restart pulses over a computed number of strobes.

// File: rtl/ocb_pkg.sv
package ocb_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_BLANK  = 2'd2,
        ST_HICCUP = 2'd3
    } ocb_state_e;

    // Which value the cycle counter loads
    typedef enum logic {
        LD_BLANK  = 1'b0,
        LD_HICCUP = 1'b1
    } ocb_load_e;

endpackage

// File: rtl/ocb_backoff.sv
// Exponent register for the blanking length; output is a one-hot length.
module ocb_backoff #(
    parameter int MAX_SHIFT = 4,
    localparam int LEN_W = MAX_SHIFT + 1,
    localparam int IDX_W = (MAX_SHIFT > 0) ? $clog2(MAX_SHIFT + 1) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             grow,
    input  logic             relax,
    output logic [LEN_W-1:0] blank_len
);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (grow) begin
            if (idx_q != IDX_W'(MAX_SHIFT)) begin
                idx_q <= idx_q + 1'b1;
            end
        end else if (relax) begin
            idx_q <= '0;
        end
    end

    // Decode the exponent into a power-of-two length
    for (genvar g = 0; g < LEN_W; g++) begin : g_len
        assign blank_len[g] = (idx_q == IDX_W'(g));
    end

endmodule

// File: rtl/ocb_cycle_counter.sv
// Down counter of switching cycles shared by blank and hiccup.
module ocb_cycle_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ocb_fsm.sv
module ocb_fsm
    import ocb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       strobe,
    input  logic       oc,
    input  logic       uv,
    input  logic       cnt_last,
    output logic       ld,
    output ocb_load_e  ld_sel,
    output logic       dec,
    output logic       bo_grow,
    output logic       bo_relax,
    output logic       bo_clr,
    output logic       hs_permit,
    output logic       shut_off,
    output logic       restart_req,
    output ocb_state_e state
);

    ocb_state_e st_q;
    ocb_state_e st_nxt;
    logic       fire;
    logic       restart_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Restart pulse register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
        end else begin
            restart_q <= fire;
        end
    end

    // Transitions: enable, trip, expire, collapse, retry, drop
    always_comb begin
        st_nxt   = st_q;
        ld       = 1'b0;
        ld_sel   = LD_BLANK;
        dec      = 1'b0;
        bo_grow  = 1'b0;
        bo_relax = 1'b0;
        bo_clr   = 1'b0;
        fire     = 1'b0;
        if (!en) begin
            st_nxt = ST_IDLE;          // drop
            bo_clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_nxt = ST_RUN;   // enable
                    bo_clr = 1'b1;
                end
                ST_RUN: begin
                    if (strobe) begin
                        if (uv) begin
                            st_nxt = ST_HICCUP;  // collapse
                            ld     = 1'b1;
                            ld_sel = LD_HICCUP;
                        end else if (oc) begin
                            st_nxt  = ST_BLANK;  // trip
                            ld      = 1'b1;
                            ld_sel  = LD_BLANK;
                            bo_grow = 1'b1;
                        end else begin
                            bo_relax = 1'b1;
                        end
                    end
                end
                ST_BLANK: begin
                    if (strobe) begin
                        if (uv) begin
                            st_nxt = ST_HICCUP;  // collapse
                            ld     = 1'b1;
                            ld_sel = LD_HICCUP;
                        end else if (cnt_last) begin
                            st_nxt = ST_RUN;     // expire
                        end else begin
                            dec = 1'b1;
                        end
                    end
                end
                ST_HICCUP: begin
                    if (strobe) begin
                        if (cnt_last) begin
                            st_nxt = ST_RUN;     // retry
                            bo_clr = 1'b1;
                            fire   = 1'b1;
                        end else begin
                            dec = 1'b1;
                        end
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        hs_permit   = (st_q == ST_RUN);
        shut_off    = (st_q == ST_HICCUP);
        restart_req = restart_q;
        state       = st_q;
    end

endmodule

// File: rtl/ocb_ctrl.sv
module ocb_ctrl
    import ocb_pkg::*;
#(
    parameter int MAX_SHIFT  = 4,
    parameter int HICCUP_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_strobe,
    input  logic oc_flag,
    input  logic uv_flag,
    output logic hs_permit,
    output logic shut_off,
    output logic restart_req
);

    localparam int LEN_W = MAX_SHIFT + 1;
    localparam int CAP   = 1 << MAX_SHIFT;
    localparam int MAXV  = (CAP > HICCUP_CYC) ? CAP : HICCUP_CYC;
    localparam int CNT_W = $clog2(MAXV + 1);

    logic             ld;
    ocb_load_e        ld_sel;
    logic             dec;
    logic             bo_grow;
    logic             bo_relax;
    logic             bo_clr;
    logic             cnt_last;
    logic [LEN_W-1:0] blank_len_w;
    logic [CNT_W-1:0] load_val;
    ocb_state_e       st_w;

    ocb_backoff #(.MAX_SHIFT(MAX_SHIFT)) u_backoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bo_clr),
        .grow      (bo_grow),
        .relax     (bo_relax),
        .blank_len (blank_len_w)
    );

    assign load_val = (ld_sel == LD_HICCUP) ? CNT_W'(HICCUP_CYC) : CNT_W'(blank_len_w);

    ocb_cycle_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (load_val),
        .dec      (dec),
        .last     (cnt_last)
    );

    ocb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .strobe      (cyc_strobe),
        .oc          (oc_flag),
        .uv          (uv_flag),
        .cnt_last    (cnt_last),
        .ld          (ld),
        .ld_sel      (ld_sel),
        .dec         (dec),
        .bo_grow     (bo_grow),
        .bo_relax    (bo_relax),
        .bo_clr      (bo_clr),
        .hs_permit   (hs_permit),
        .shut_off    (shut_off),
        .restart_req (restart_req),
        .state       (st_w)
    );

endmodule

// File: rtl/ocb_ctrl_chk.sv
module ocb_ctrl_chk
    import ocb_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             cyc_strobe,
    input logic             oc_flag,
    input logic             uv_flag,
    input logic             hs_permit,
    input logic             shut_off,
    input logic             restart_req,
    input ocb_state_e       st,
    input logic [LEN_W-1:0] blank_len
);

    // R10: disable forces every output low
    a_r10_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_permit && !shut_off && !restart_req));

    // R2: overcurrent in RUN suppresses the high side next clock
    a_r2_trip_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cyc_strobe && hs_permit && oc_flag && !uv_flag) |=> (!hs_permit && !shut_off));

    // R9: undervoltage beats overcurrent at the same strobe
    a_r9_uv_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cyc_strobe && uv_flag && oc_flag && (st == ST_RUN || st == ST_BLANK)) |=> shut_off);

    // R8: restart is a single-clock pulse, comes out of hiccup, clears backoff
    a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    a_r8_from_hiccup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_req) |-> ($past(shut_off) && blank_len == LEN_W'(1)));

    // R6: strobes inside a blank do not move the backoff
    a_r6_blank_ignores_oc: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cyc_strobe && st == ST_BLANK && !uv_flag) |=> $stable(blank_len));

    // R12: no output change between strobes while active
    a_r12_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cyc_strobe && st != ST_IDLE) |=> ($stable(hs_permit) && $stable(shut_off)));

endmodule

bind ocb_ctrl ocb_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .cyc_strobe  (cyc_strobe),
    .oc_flag     (oc_flag),
    .uv_flag     (uv_flag),
    .hs_permit   (hs_permit),
    .shut_off    (shut_off),
    .restart_req (restart_req),
    .st          (st_w),
    .blank_len   (blank_len_w)
);

// File: tb/ocb_ctrl_tb_top.sv
`timescale 1ns/1ps
module ocb_ctrl_tb_top;

    localparam int MAX_SHIFT  = 4;
    localparam int HICCUP_CYC = 6;
    localparam int CAP        = 1 << MAX_SHIFT;

    logic clk = 1'b0;
    logic rst_n, en, stb, oc, uv;
    logic permit, shut, rreq;

    always #2 clk = ~clk;

    ocb_ctrl #(.MAX_SHIFT(MAX_SHIFT), .HICCUP_CYC(HICCUP_CYC)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .cyc_strobe  (stb),
        .oc_flag     (oc),
        .uv_flag     (uv),
        .hs_permit   (permit),
        .shut_off    (shut),
        .restart_req (rreq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int seen_rst = 0;

    // Requirement-level model: 0 idle, 1 run, 2 blank, 3 hiccup
    int m_mode = 0;
    int m_len  = 1;
    int m_cnt  = 0;
    int m_rst  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input bit o, input bit u);
        m_rst = 0;
        case (m_mode)
            1: begin
                if (u) begin m_mode = 3; m_cnt = HICCUP_CYC; end
                else if (o) begin
                    m_mode = 2; m_cnt = m_len;
                    m_len = (m_len * 2 > CAP) ? CAP : m_len * 2;
                end else m_len = 1;
            end
            2: begin
                if (u) begin m_mode = 3; m_cnt = HICCUP_CYC; end
                else if (m_cnt == 1) m_mode = 1;
                else m_cnt--;
            end
            3: begin
                if (m_cnt == 1) begin m_mode = 1; m_len = 1; m_rst = 1; end
                else m_cnt--;
            end
            default: ;
        endcase
    endtask

    task automatic sw_cycle(input bit o, input bit u, input string tag);
        @(negedge clk);
        stb = 1'b1; oc = o; uv = u;
        @(negedge clk);
        stb = 1'b0; oc = 1'b0; uv = 1'b0;
        model_step(o, u);
        chk({tag, " permit"}, int'(permit), int'(m_mode == 1));
        chk({tag, " shut_off"}, int'(shut), int'(m_mode == 3));
        chk({tag, " restart"}, int'(rreq), m_rst);
        if (rreq) seen_rst++;
        @(negedge clk);
        chk("R8 pulse width", int'(rreq), 0);
        chk("R12 hold permit", int'(permit), int'(m_mode == 1));
    endtask

    task automatic set_en(input bit e, input string tag);
        @(negedge clk);
        en = e;
        @(negedge clk);
        if (e) begin m_mode = 1; m_len = 1; end
        else m_mode = 0;
        m_rst = 0;
        chk({tag, " permit"}, int'(permit), int'(m_mode == 1));
        chk({tag, " shut_off"}, int'(shut), 0);
        chk({tag, " restart"}, int'(rreq), 0);
    endtask

    // Trip once, then count strobes until the high side is permitted again
    task automatic blank_run(input bit oc_during, input int exp, input string tag);
        int n;
        n = 0;
        sw_cycle(1'b1, 1'b0, tag);
        while (permit == 1'b0 && n < 40) begin
            sw_cycle(oc_during, 1'b0, tag);
            n++;
        end
        chk({tag, " blank length"}, n, exp);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        int n;
        rst_n = 1'b0; en = 1'b0; stb = 1'b0; oc = 1'b0; uv = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset permit", int'(permit), 0);
        chk("R1 reset shut_off", int'(shut), 0);
        chk("R1 reset restart", int'(rreq), 0);
        rst_n = 1'b1;
        sw_cycle(1'b1, 1'b0, "R10 disabled");
        set_en(1'b1, "R1 enable");

        // R2 first trip, R3 doubling, R4 ceiling
        blank_run(1'b0, 1, "R2");
        for (int k = 1; k <= MAX_SHIFT; k++) blank_run(1'b0, 1 << k, "R3");
        blank_run(1'b0, CAP, "R4");
        blank_run(1'b0, CAP, "R4");

        // R5 clean cycle resets
        sw_cycle(1'b0, 1'b0, "R5");
        blank_run(1'b0, 1, "R5");
        sw_cycle(1'b0, 1'b0, "R5");

        // R6 overcurrent during blank ignored
        blank_run(1'b1, 1, "R6");
        blank_run(1'b1, 2, "R6");
        blank_run(1'b1, 4, "R6");
        sw_cycle(1'b0, 1'b0, "R6");

        // R7 hiccup length, R8 restart clears backoff
        blank_run(1'b0, 1, "R7");
        blank_run(1'b0, 2, "R7");
        sw_cycle(1'b0, 1'b1, "R7");
        n = 0;
        while (shut == 1'b1 && n < 40) begin
            sw_cycle(1'b0, 1'b0, "R7");
            n++;
        end
        chk("R7 off cycles", n, HICCUP_CYC);
        blank_run(1'b0, 1, "R8");

        // R9 coincident faults in RUN and in BLANK
        sw_cycle(1'b1, 1'b1, "R9 run");
        for (int i = 0; i < HICCUP_CYC; i++) sw_cycle(1'b0, 1'b0, "R9");
        sw_cycle(1'b1, 1'b0, "R9");
        sw_cycle(1'b1, 1'b0, "R9");
        sw_cycle(1'b1, 1'b0, "R9");
        sw_cycle(1'b1, 1'b1, "R9 blank");
        for (int i = 0; i < HICCUP_CYC; i++) sw_cycle(1'b0, 1'b0, "R9");

        // R11 persistent undervoltage repeats the hiccup
        seen_rst = 0;
        for (int i = 0; i < 2 * (HICCUP_CYC + 1); i++) sw_cycle(1'b0, 1'b1, "R11");
        chk("R11 restarts", seen_rst, 2);

        // R10 disable mid-blank and mid-hiccup
        blank_run(1'b0, 1, "R10");
        blank_run(1'b0, 2, "R10");
        sw_cycle(1'b1, 1'b0, "R10");
        sw_cycle(1'b0, 1'b0, "R10");
        set_en(1'b0, "R10 drop");
        sw_cycle(1'b1, 1'b0, "R10 disabled");
        sw_cycle(1'b0, 1'b1, "R10 disabled");
        set_en(1'b1, "R10 enable");
        blank_run(1'b0, 1, "R10");
        sw_cycle(1'b0, 1'b1, "R10");
        set_en(1'b0, "R10 drop hiccup");
        set_en(1'b1, "R10 enable");

        // Sweep of pseudo-random fault patterns against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sw_cycle(lfsr[0] | lfsr[5], lfsr[7:4] == 4'h0, "SWEEP R3");
        end

        summary();
        $finish;
    end

endmodule